// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a 32-bit processor core that runs a small subset of a classic load/store instruction set: word load, word store, register-register arithmetic, branch-if-equal and an absolute jump. Each instruction passes through a sequence of clock cycles chosen by a state machine. One ALU is reused across these cycles to increment the PC, form the branch target and perform the execution step. Between cycles the intermediate values stay in internal holding registers: the instruction register, the memory data register, two operand latches and an ALU result latch.

The core contains the PC, a general register file and the controller. Memory sits outside the core behind a single port that serves both instruction fetch and data access. The core drives an address, write data and a write strobe. The memory returns read data for the presented address in the same cycle, and it commits a write at the rising clock edge that ends a cycle in which the strobe is high. The control state machine produces a small bundle of strobes that steers the datapath in each cycle.

Top module: `mcpu_core`

## Requirements
- R1: While the synchronous reset `rst` is high, the PC is 0 and `memWe` is low. The first cycle after reset fetches from address 0.
- R2: Every instruction starts with a fetch cycle that reads the word at the PC and advances the PC by 4, followed by a decode cycle.
- R3: Opcode 0x00 executes in 4 cycles and writes field rd (bits 15:11) with the result selected by bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0).
- R4: Opcode 0x23 executes in 5 cycles and writes the word at address rs + sign-extended bits 15:0 into register rt (bits 20:16).
- R5: Opcode 0x2B executes in 4 cycles. It raises `memWe` for one cycle only, the last one, with the address rs + sign-extended offset and the data from register rt.
- R6: Opcode 0x04 executes in 3 cycles. When rs equals rt, the next fetch address is the incremented PC plus the sign-extended offset shifted left by 2 (forward or backward). Otherwise the next fetch address is the incremented PC.
- R7: Opcode 0x02 executes in 3 cycles. The next fetch address is bits 31:28 of the incremented PC joined with bits 25:0 shifted left by 2.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: Any other opcode takes 2 cycles and changes neither registers nor memory. Fetch then continues at the next word.
- R10: Every fetch address is word aligned, and no fetch cycle writes memory.
- R11: Load and store offsets are sign-extended, so a negative offset addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | XLEN | Memory address: the PC in fetch, the computed address in data cycles |
| memWrData | output | XLEN | Store data |
| memWe | output | 1 | Write strobe, committed at the end of the cycle |
| memRdData | input | XLEN | Read data for `memAddr`, valid in the same cycle |

## Verification
The bench builds the core with its defaults: a 32-bit word and 32 registers. At these values the encodings use their full 5-bit register fields. The signed compare can be checked where it differs from an unsigned one, and the jump concatenation keeps its full 4-bit upper part. Each scenario loads a short program into a bench memory model. The bench observes only the memory port: it checks the fetch address in chosen cycles, the cycle in which each store commits, and the stored values. These observations establish the cycle count of each instruction class, the branch and jump targets, and the values held in registers.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    PH_FETCH, PH_DECODE, PH_ADDR, PH_LOAD, PH_STORE,
    PH_LOADWB, PH_EXEC, PH_RWB, PH_BRANCH, PH_JUMP
  } phase_e;

  typedef enum logic [1:0] { SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BROFF } srcB_e;
  typedef enum logic [1:0] { ALU_ADD, ALU_SUB, ALU_FUNCT } aluSel_e;
  typedef enum logic [1:0] { PC_FROM_ALU, PC_FROM_LATCH, PC_FROM_JUMP } pcSrc_e;

  typedef struct packed {
    logic    addrFromLatch;
    logic    memWe;
    logic    irLoad;
    logic    mdrLoad;
    logic    abLoad;
    logic    latchLoad;
    logic    pcLoad;
    logic    pcOnEqual;
    pcSrc_e  pcSrc;
    logic    srcAFromReg;
    srcB_e   srcB;
    aluSel_e aluSel;
    logic    regWe;
    logic    dstIsRd;
    logic    wbFromMem;
  } strobes_t;

endpackage

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output phase_e     phase,
  output strobes_t   stb
);

  phase_e nextPhase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= nextPhase;
  end

  always_comb begin
    nextPhase = PH_FETCH;
    case (phase)
      PH_FETCH:  nextPhase = PH_DECODE;
      PH_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: nextPhase = PH_ADDR;
          OP_RTYPE:          nextPhase = PH_EXEC;
          OP_BEQ:            nextPhase = PH_BRANCH;
          OP_JUMP:           nextPhase = PH_JUMP;
          default:           nextPhase = PH_FETCH;
        endcase
      end
      PH_ADDR:   nextPhase = (opcode == OP_LOAD) ? PH_LOAD : PH_STORE;
      PH_LOAD:   nextPhase = PH_LOADWB;
      PH_EXEC:   nextPhase = PH_RWB;
      default:   nextPhase = PH_FETCH;
    endcase
  end

  always_comb begin
    stb = '0;
    case (phase)
      PH_FETCH: begin
        stb.irLoad = 1'b1;
        stb.pcLoad = 1'b1;
        stb.pcSrc  = PC_FROM_ALU;
        stb.srcB   = SRCB_FOUR;
        stb.aluSel = ALU_ADD;
      end
      PH_DECODE: begin
        stb.abLoad    = 1'b1;
        stb.latchLoad = 1'b1;
        stb.srcB      = SRCB_BROFF;
        stb.aluSel    = ALU_ADD;
      end
      PH_ADDR: begin
        stb.srcAFromReg = 1'b1;
        stb.srcB        = SRCB_IMM;
        stb.aluSel      = ALU_ADD;
        stb.latchLoad   = 1'b1;
      end
      PH_LOAD: begin
        stb.addrFromLatch = 1'b1;
        stb.mdrLoad       = 1'b1;
      end
      PH_STORE: begin
        stb.addrFromLatch = 1'b1;
        stb.memWe         = 1'b1;
      end
      PH_LOADWB: begin
        stb.regWe     = 1'b1;
        stb.wbFromMem = 1'b1;
      end
      PH_EXEC: begin
        stb.srcAFromReg = 1'b1;
        stb.srcB        = SRCB_REG;
        stb.aluSel      = ALU_FUNCT;
        stb.latchLoad   = 1'b1;
      end
      PH_RWB: begin
        stb.regWe   = 1'b1;
        stb.dstIsRd = 1'b1;
      end
      PH_BRANCH: begin
        stb.srcAFromReg = 1'b1;
        stb.srcB        = SRCB_REG;
        stb.aluSel      = ALU_SUB;
        stb.pcOnEqual   = 1'b1;
        stb.pcSrc       = PC_FROM_LATCH;
      end
      PH_JUMP: begin
        stb.pcLoad = 1'b1;
        stb.pcSrc  = PC_FROM_JUMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int REG_AW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] wAddr,
  input  logic [XLEN-1:0]   wData,
  input  logic [REG_AW-1:0] rAddrA,
  input  logic [REG_AW-1:0] rAddrB,
  output logic [XLEN-1:0]   rDataA,
  output logic [XLEN-1:0]   rDataB
);

  logic [XLEN-1:0] cells [NREGS];

  always_ff @(posedge clk) begin
    if (we && (wAddr != '0)) cells[wAddr] <= wData;
  end

  // Entry 0 is never read from storage: it is wired to zero.
  assign rDataA = (rAddrA == '0) ? '0 : cells[rAddrA];
  assign rDataB = (rAddrB == '0) ? '0 : cells[rAddrB];

endmodule

// File: rtl/mcpu_dpath.sv
module mcpu_dpath
  import mcpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int REG_AW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        stb,
  input  logic [XLEN-1:0] memRdData,
  output logic [5:0]      opcode,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData
);

  logic [XLEN-1:0] pc, ir, mdr, opA, opB, aluLatch;
  logic [XLEN-1:0] rfA, rfB, aluIn1, aluIn2, aluRes, sext, wbData, jumpTarget, pcNext;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx;
  logic aluZero, pcWrite;

  assign opcode = ir[31:26];
  assign rsIdx  = ir[21 +: REG_AW];
  assign rtIdx  = ir[16 +: REG_AW];
  assign rdIdx  = ir[11 +: REG_AW];
  assign sext   = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign jumpTarget = {pc[XLEN-1:28], ir[25:0], 2'b00};
  assign wbData = stb.wbFromMem ? mdr : aluLatch;

  mcpu_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk   (clk),
    .we    (stb.regWe),
    .wAddr (stb.dstIsRd ? rdIdx : rtIdx),
    .wData (wbData),
    .rAddrA(rsIdx),
    .rAddrB(rtIdx),
    .rDataA(rfA),
    .rDataB(rfB)
  );

  assign aluIn1 = stb.srcAFromReg ? opA : pc;

  always_comb begin
    case (stb.srcB)
      SRCB_REG:  aluIn2 = opB;
      SRCB_FOUR: aluIn2 = XLEN'(4);
      SRCB_IMM:  aluIn2 = sext;
      default:   aluIn2 = {sext[XLEN-3:0], 2'b00};
    endcase
  end

  always_comb begin
    aluRes = aluIn1 + aluIn2;
    if (stb.aluSel == ALU_SUB) begin
      aluRes = aluIn1 - aluIn2;
    end else if (stb.aluSel == ALU_FUNCT) begin
      case (ir[5:0])
        FN_SUB:  aluRes = aluIn1 - aluIn2;
        FN_AND:  aluRes = aluIn1 & aluIn2;
        FN_OR:   aluRes = aluIn1 | aluIn2;
        FN_SLT:  aluRes = {{(XLEN-1){1'b0}}, ($signed(aluIn1) < $signed(aluIn2))};
        default: aluRes = aluIn1 + aluIn2;
      endcase
    end
  end

  assign aluZero = (aluRes == '0);
  assign pcWrite = stb.pcLoad | (stb.pcOnEqual & aluZero);

  always_comb begin
    case (stb.pcSrc)
      PC_FROM_LATCH: pcNext = aluLatch;
      PC_FROM_JUMP:  pcNext = jumpTarget;
      default:       pcNext = aluRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ir       <= '0;
      mdr      <= '0;
      opA      <= '0;
      opB      <= '0;
      aluLatch <= '0;
    end else begin
      if (pcWrite)        pc       <= pcNext;
      if (stb.irLoad)     ir       <= memRdData;
      if (stb.mdrLoad)    mdr      <= memRdData;
      if (stb.abLoad)     opA      <= rfA;
      if (stb.abLoad)     opB      <= rfB;
      if (stb.latchLoad)  aluLatch <= aluRes;
    end
  end

  assign memAddr   = stb.addrFromLatch ? aluLatch : pc;
  assign memWrData = opB;

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic            memWe,
  input  logic [XLEN-1:0] memRdData
);

  strobes_t   stb;
  phase_e     phaseW;
  logic [5:0] opcodeW;

  mcpu_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .opcode(opcodeW),
    .phase (phaseW),
    .stb   (stb)
  );

  mcpu_dpath #(.XLEN(XLEN), .NREGS(NREGS)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .memRdData(memRdData),
    .opcode   (opcodeW),
    .memAddr  (memAddr),
    .memWrData(memWrData)
  );

  assign memWe = stb.memWe;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
  import mcpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input phase_e          phase,
  input logic [XLEN-1:0] memAddr,
  input logic            memWe
);

  logic [2:0] instrAge;

  always_ff @(posedge clk) begin
    if (rst)                   instrAge <= '0;
    else if (phase == PH_FETCH) instrAge <= 3'd1;
    else if (instrAge != 3'd7) instrAge <= instrAge + 3'd1;
  end

  // R1: leaving reset starts a fetch at address 0
  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase == PH_FETCH && memAddr == '0 && !memWe));

  // R2: fetch is always followed by decode
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (phase == PH_DECODE));

  // R2: no instruction lasts beyond five cycles
  a_r2_max_length: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_FETCH) |-> (instrAge <= 3'd4));

  // R4: register write from memory only follows the memory read cycle
  a_r4_wb_after_read: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOADWB) |-> ($past(phase) == PH_LOAD));

  // R5: a store write is the last cycle of its instruction
  a_r5_store_ends: assert property (@(posedge clk) disable iff (rst)
    memWe |=> (phase == PH_FETCH));

  // R6, R7: branch and jump finish in their third cycle
  a_r6_r7_flow_ends: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BRANCH || phase == PH_JUMP) |=> (phase == PH_FETCH));

  // R10: fetch addresses are aligned and never write
  a_r10_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |-> (memAddr[1:0] == 2'b00 && !memWe));

endmodule

bind mcpu_core mcpu_core_chk #(.XLEN(XLEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .phase  (phaseW),
  .memAddr(memAddr),
  .memWe  (memWe)
);

// File: tb/sim_mcpu_core.sv
module sim_mcpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memAddr, memWrData, memRdData;
  logic        memWe;

  logic [31:0] img [256];
  logic [31:0] mem [256];
  int          cyc, wrCount, firstWr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  mcpu_core u0 (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memWe    (memWe),
    .memRdData(memRdData)
  );

  assign memRdData = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      cyc     <= 0;
      wrCount <= 0;
      firstWr <= -1;
    end else begin
      if (memWe) begin
        mem[memAddr[9:2]] <= memWrData;
        wrCount <= wrCount + 1;
        if (firstWr < 0) firstWr <= cyc;
      end
      cyc <= cyc + 1;
    end
  end

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < 256; i++) img[i] = 32'h0;
  endtask

  // Hold reset, check the reset state, release it at a falling edge (cycle 0 begins)
  task automatic startRun();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset address", memAddr, 32'h0);
    check("R1 reset write strobe", {31'd0, memWe}, 32'h0);
    rst = 1'b0;
    check("R1 first fetch at 0", memAddr, 32'h0);
  endtask

  // Move to the middle of cycle n counted from release
  task automatic gotoCycle(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic testArith();
    clearImg();
    img[8'h40] = 32'd7;
    img[8'h41] = 32'hFFFF_FFFD;
    img[0]  = encI(6'h23, 5'd0, 5'd1, 16'h0100);
    img[1]  = encI(6'h23, 5'd0, 5'd2, 16'h0104);
    img[2]  = encR(5'd1, 5'd2, 5'd3, 6'h20);
    img[3]  = encR(5'd1, 5'd2, 5'd4, 6'h22);
    img[4]  = encR(5'd1, 5'd2, 5'd5, 6'h24);
    img[5]  = encR(5'd1, 5'd2, 5'd6, 6'h25);
    img[6]  = encR(5'd2, 5'd1, 5'd7, 6'h2A);
    img[7]  = encR(5'd1, 5'd2, 5'd8, 6'h2A);
    for (int k = 0; k < 6; k++) img[8 + k] = encI(6'h2B, 5'd0, 5'(3 + k), 16'(16'h0200 + 4 * k));
    img[14] = encJ(26'h0E);
    startRun();
    gotoCycle(5);
    check("R4 load takes 5 cycles", memAddr, 32'h4);
    gotoCycle(10);
    check("R2 fetch at PC+4", memAddr, 32'h8);
    gotoCycle(14);
    check("R3 arithmetic takes 4 cycles", memAddr, 32'hC);
    gotoCycle(70);
    check("R3 add", mem[8'h80], 32'd4);
    check("R3 sub", mem[8'h81], 32'd10);
    check("R3 and", mem[8'h82], 32'd5);
    check("R3 or", mem[8'h83], 32'hFFFF_FFFF);
    check("R3 slt signed true", mem[8'h84], 32'd1);
    check("R3 slt signed false", mem[8'h85], 32'd0);
    check("R5 first store cycle", firstWr, 32'd37);
    check("R5 store count", wrCount, 32'd6);
  endtask

  task automatic testOffsets();
    clearImg();
    img[8'h42] = 32'h120;
    img[8'h46] = 32'hA5A5_0001;
    img[8'h81] = 32'hFFFF_FFFF;
    img[0] = encI(6'h23, 5'd0, 5'd9, 16'h0108);
    img[1] = encI(6'h23, 5'd9, 5'd10, 16'hFFF8);
    img[2] = encI(6'h2B, 5'd9, 5'd10, 16'hFFFC);
    img[3] = encR(5'd9, 5'd9, 5'd0, 6'h20);
    img[4] = encI(6'h2B, 5'd0, 5'd0, 16'h0204);
    img[5] = encJ(26'h05);
    startRun();
    gotoCycle(40);
    check("R11 negative offsets", mem[8'h47], 32'hA5A5_0001);
    check("R5 store after two loads", firstWr, 32'd13);
    check("R8 register 0 stays zero", mem[8'h81], 32'h0);
    check("R5 store count offsets", wrCount, 32'd2);
  endtask

  task automatic testBranch();
    clearImg();
    img[8'h40] = 32'd7;
    img[8'h80] = 32'hDEAD_0001;
    img[8'h82] = 32'hDEAD_0003;
    img[0] = encI(6'h23, 5'd0, 5'd1, 16'h0100);
    img[1] = encI(6'h23, 5'd0, 5'd2, 16'h0100);
    img[2] = encI(6'h04, 5'd1, 5'd2, 16'h0001);
    img[3] = encI(6'h2B, 5'd0, 5'd1, 16'h0200);
    img[4] = encI(6'h04, 5'd1, 5'd0, 16'h0002);
    img[5] = encI(6'h2B, 5'd0, 5'd2, 16'h0204);
    img[6] = encI(6'h04, 5'd0, 5'd0, 16'hFFFF);
    img[7] = encI(6'h2B, 5'd0, 5'd1, 16'h0208);
    startRun();
    gotoCycle(13);
    check("R6 taken branch target", memAddr, 32'h10);
    gotoCycle(16);
    check("R6 untaken branch falls through", memAddr, 32'h14);
    gotoCycle(23);
    check("R6 backward branch", memAddr, 32'h18);
    gotoCycle(40);
    check("R6 skipped store", mem[8'h80], 32'hDEAD_0001);
    check("R6 store after branches", mem[8'h81], 32'd7);
    check("R6 store cycle", firstWr, 32'd19);
    check("R6 beyond loop untouched", mem[8'h82], 32'hDEAD_0003);
  endtask

  task automatic testJump();
    clearImg();
    img[8'h40] = 32'd7;
    img[8'h80] = 32'hDEAD_0001;
    img[0]  = encI(6'h23, 5'd0, 5'd1, 16'h0100);
    img[1]  = encJ(26'h10);
    img[2]  = encI(6'h2B, 5'd0, 5'd1, 16'h0200);
    img[16] = encI(6'h2B, 5'd0, 5'd1, 16'h0204);
    img[17] = encJ(26'h11);
    startRun();
    gotoCycle(8);
    check("R7 jump target fetch", memAddr, 32'h40);
    gotoCycle(30);
    check("R7 skipped store", mem[8'h80], 32'hDEAD_0001);
    check("R7 store at target", mem[8'h81], 32'd7);
    check("R7 jump takes 3 cycles", firstWr, 32'd11);
  endtask

  task automatic testUnknown();
    clearImg();
    img[8'h40] = 32'd7;
    img[0] = encI(6'h23, 5'd0, 5'd1, 16'h0100);
    img[1] = {6'h3F, 5'd1, 5'd1, 5'd1, 5'd0, 6'h20};
    img[2] = encI(6'h2B, 5'd0, 5'd1, 16'h0200);
    img[3] = encJ(26'h03);
    startRun();
    gotoCycle(7);
    check("R9 unknown opcode takes 2 cycles", memAddr, 32'h8);
    gotoCycle(30);
    check("R9 register unchanged", mem[8'h80], 32'd7);
    check("R9 store cycle", firstWr, 32'd10);
    check("R10 single write", wrCount, 32'd1);
  endtask

  initial begin
    clearImg();
    testArith();
    testOffsets();
    testBranch();
    testJump();
    testUnknown();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule